// File: doc/BRIEF.md
# Streaming CRC Engine with Word Reordering

This block keeps a running CRC over a stream of 32-bit input writes. Each write with `din_valid` high updates the running value in one clock cycle, so the host can push one word or byte per cycle. Before the update, the input word goes through a reordering stage. A 2-bit swap control exchanges bytes inside each half-word, exchanges the two half-words, or does both. A bit-reverse option then mirrors the bits inside every byte.

A size control picks word mode, where all 32 bits enter the CRC, or byte mode, where only the low input byte enters it. A type control picks CRC-32 (polynomial 0x04C11DB7) or the 16-bit CCITT code (polynomial 0x1021). The running value starts at all zeros, at all ones, or at a stored seed. The host writes configuration, seed and data through a plain strobe-and-data port, and `crc_out` always shows the current running value. No final XOR is applied to that value.

Top module: `crc_stream_engine`

## Requirements
- R1: While `rst_n` is low, `crc_out` is 0. Reset also clears every configuration field to 0: swap code 0, no bit reverse, word mode, CRC-32 and init selection 0.
- R2: With swap code `cfg_endian` and input bytes {B3,B2,B1,B0} (B0 = bits 7:0), the word that enters the CRC is {B3,B2,B1,B0} for code 0, {B2,B3,B0,B1} for code 1, {B1,B0,B3,B2} for code 2 and {B0,B1,B2,B3} for code 3.
- R3: When `cfg_bitrev` is 1, the bits inside each byte are mirrored after the swap stage, so bit 7 of a byte becomes bit 0. Byte positions stay as the swap stage left them.
- R4: When `cfg_bytemode` is 1, only `din_data[7:0]` enters the CRC, bit-reversed if `cfg_bitrev` is 1, as 8 bits. Bits 31:8 and the swap code have no effect in this mode.
- R5: With `cfg_crc16` at 0, each accepted input updates the CRC with polynomial 0x04C11DB7, most significant bit first. The new value appears on `crc_out` in the cycle after the write. No final XOR is applied.
- R6: With `cfg_crc16` at 1, the update uses polynomial 0x1021 on bits 15:0, most significant bit first, and clears bits 31:16 of the running value. In this mode `crc_out[31:16]` reads 0.
- R7: A `start` pulse loads the running value from the stored init selection: 0 gives all zeros, 1 gives all ones, and 2 or 3 gives the stored seed.
- R8: `seed_we` stores `seed_data` as the seed and also loads it as the running value in the same cycle. When `seed_we` and `start` are both high, the seed write wins.
- R9: If `seed_we` or `start` is high in the same cycle as `din_valid`, the load wins and that data input is dropped.
- R10: A configuration write takes effect from the next cycle. A data input or `start` in the same cycle as `cfg_we` uses the configuration that was stored before the write.
- R11: When none of `cfg_we`, `seed_we`, `start` or `din_valid` is high, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Writes the configuration fields below |
| cfg_endian | input | 2 | Swap code for bytes and half-words |
| cfg_bitrev | input | 1 | Mirrors the bits inside each byte |
| cfg_bytemode | input | 1 | 1 = byte mode, 0 = word mode |
| cfg_crc16 | input | 1 | 1 = 16-bit CCITT, 0 = CRC-32 |
| cfg_init_sel | input | 2 | Start value: 0 zeros, 1 ones, 2/3 seed |
| start | input | 1 | Loads the running value from the init selection |
| seed_we | input | 1 | Stores the seed and loads the running value |
| seed_data | input | 32 | Seed value |
| din_valid | input | 1 | Data input strobe |
| din_data | input | 32 | Data input word |
| crc_out | output | 32 | Current running CRC |

## Verification
A load can arrive in the same cycle as a data input. This covers a seed write or a start pulse together with `din_valid`, and also a configuration write together with data. The bench drives these pairs on purpose, in the middle of streams and across every type, size and reorder setting. A behavioural model built from queues of byte positions and a bit-serial divider predicts the running value on every clock. A pairing is correct only when the loaded value appears untouched and the dropped word leaves no trace. When data meets a configuration write, the data must be folded with the old settings.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam logic [31:0] POLY_WIDE   = 32'h04C1_1DB7;
  localparam logic [15:0] POLY_NARROW = 16'h1021;

  typedef enum logic [1:0] {
    INIT_ZERO  = 2'd0,
    INIT_ONES  = 2'd1,
    INIT_SEED  = 2'd2,
    INIT_SEED2 = 2'd3
  } init_sel_e;

  typedef struct packed {
    init_sel_e  init_sel;
    logic       crc16;
    logic       bytemode;
    logic       bitrev;
    logic [1:0] endian;
  } crc_cfg_t;
endpackage

// File: rtl/crc_word_shaper.sv
module crc_word_shaper #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        swap_code,
  input  logic              bitrev,
  input  logic              bytemode,
  output logic [DATA_W-1:0] shaped
);
  localparam int unsigned NLANE = DATA_W / BYTE_W;
  localparam int unsigned IDX_W = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] mirrored;
  logic [BYTE_W-1:0] low_lane;

  // lane k takes input lane (k xor swap_code): bit 0 swaps inside half-words, bit 1 swaps halves
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
    logic [IDX_W-1:0] src;
    assign src = K_IDX ^ IDX_W'(swap_code);
    assign swapped[k*BYTE_W +: BYTE_W] = din[src*BYTE_W +: BYTE_W];
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign mirrored[k*BYTE_W + b] = swapped[k*BYTE_W + (BYTE_W-1-b)];
    end
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_low
    assign low_lane[b] = bitrev ? din[BYTE_W-1-b] : din[b];
  end

  // result is top-aligned: the update unit consumes from the MSB down
  always_comb begin
    if (bytemode) begin
      shaped = {low_lane, {(DATA_W-BYTE_W){1'b0}}};
    end else if (bitrev) begin
      shaped = mirrored;
    end else begin
      shaped = swapped;
    end
  end
endmodule

// File: rtl/crc_update_unit.sv
module crc_update_unit #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CRC_W     = 32,
  parameter logic [31:0] POLY_W    = 32'h04C1_1DB7,
  parameter logic [15:0] POLY_H    = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data,
  input  logic              narrow,
  input  logic              bytemode,
  output logic [CRC_W-1:0]  crc_next
);
  localparam int unsigned HALF_W = CRC_W / 2;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                            input logic d,
                                            input logic sel16);
    logic fb;
    logic [CRC_W-1:0] r;
    if (sel16) begin
      fb = c[HALF_W-1] ^ d;
      r  = {{HALF_W{1'b0}}, c[HALF_W-2:0], 1'b0};
      if (fb) r[HALF_W-1:0] = r[HALF_W-1:0] ^ POLY_H[HALF_W-1:0];
    end else begin
      fb = c[CRC_W-1] ^ d;
      r  = {c[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY_W[CRC_W-1:0];
    end
    return r;
  endfunction

  logic [DATA_W:0][CRC_W-1:0] stage;
  assign stage[0] = crc_in;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_step
    assign stage[gi+1] = step(stage[gi], data[DATA_W-1-gi], narrow);
  end

  assign crc_next = bytemode ? stage[BYTE_W] : stage[DATA_W];
endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine
  import crc_stream_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned BYTE_W = LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_endian,
  input  logic              cfg_bitrev,
  input  logic              cfg_bytemode,
  input  logic              cfg_crc16,
  input  logic [1:0]        cfg_init_sel,
  input  logic              start,
  input  logic              seed_we,
  input  logic [DATA_W-1:0] seed_data,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic [DATA_W-1:0] crc_out
);
  localparam int unsigned HALF_W = DATA_W / 2;

  crc_cfg_t          cfg_q, cfg_d;
  logic [DATA_W-1:0] seed_q, seed_d;
  logic [DATA_W-1:0] crc_q, crc_d;
  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] crc_upd;
  logic [DATA_W-1:0] init_val;
  logic              crc_en;

  crc_word_shaper #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shaper (
    .din       (din_data),
    .swap_code (cfg_q.endian),
    .bitrev    (cfg_q.bitrev),
    .bytemode  (cfg_q.bytemode),
    .shaped    (shaped)
  );

  crc_update_unit #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .CRC_W  (DATA_W),
    .POLY_W (POLY_WIDE),
    .POLY_H (POLY_NARROW)
  ) u_update (
    .crc_in   (crc_q),
    .data     (shaped),
    .narrow   (cfg_q.crc16),
    .bytemode (cfg_q.bytemode),
    .crc_next (crc_upd)
  );

  always_comb begin
    unique case (cfg_q.init_sel)
      INIT_ZERO: init_val = '0;
      INIT_ONES: init_val = '1;
      default:   init_val = seed_q;
    endcase
  end

  assign crc_en = seed_we | start | din_valid;

  always_comb begin
    cfg_d  = cfg_q;
    seed_d = seed_q;
    crc_d  = crc_q;
    if (cfg_we) begin
      cfg_d = '{init_sel: init_sel_e'(cfg_init_sel), crc16: cfg_crc16,
                bytemode: cfg_bytemode, bitrev: cfg_bitrev, endian: cfg_endian};
    end
    if (seed_we) begin
      seed_d = seed_data;
      crc_d  = seed_data;
    end else if (start) begin
      crc_d  = init_val;
    end else if (din_valid) begin
      crc_d  = crc_upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      seed_q <= '0;
      crc_q  <= '0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_d;
      if (seed_we) seed_q <= seed_d;
      if (crc_en)  crc_q  <= crc_d;
    end
  end

  assign crc_out = cfg_q.crc16 ? {{HALF_W{1'b0}}, crc_q[HALF_W-1:0]} : crc_q;
endmodule

// File: rtl/crc_stream_chk.sv
module crc_stream_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              seed_we,
  input logic              start,
  input logic              din_valid,
  input logic [DATA_W-1:0] seed_data,
  input logic [DATA_W-1:0] crc_out,
  input logic              narrow_q,
  input logic [1:0]        init_sel_q
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (crc_out == '0);
    end
  end

  p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_q |-> crc_out[DATA_W-1:HALF_W] == '0);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !seed_we && !start && !din_valid) |=> $stable(crc_out));

  p_seed_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && !cfg_we && !narrow_q) |=> crc_out == $past(seed_data));

  p_start_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !seed_we && !cfg_we && !narrow_q && init_sel_q == 2'd1) |=> crc_out == '1);

  p_start_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !seed_we && !cfg_we && init_sel_q == 2'd0) |=> crc_out == '0);

  p_load_beats_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && din_valid && !cfg_we && !narrow_q) |=> crc_out == $past(seed_data));
endmodule

bind crc_stream_engine crc_stream_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .seed_we    (seed_we),
  .start      (start),
  .din_valid  (din_valid),
  .seed_data  (seed_data),
  .crc_out    (crc_out),
  .narrow_q   (cfg_q.crc16),
  .init_sel_q (cfg_q.init_sel)
);

// File: tb/crc_stream_engine_tb_top.sv
`timescale 1ns/1ps
module crc_stream_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_bitrev, cfg_bytemode, cfg_crc16, start, seed_we, din_valid;
  logic [1:0]  cfg_endian, cfg_init_sel;
  logic [31:0] seed_data, din_data, crc_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  logic [31:0] m_crc, m_seed;
  logic [1:0]  m_endian, m_init;
  logic        m_rev, m_byte, m_n16;

  always #2.5 clk = ~clk;

  crc_stream_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_endian(cfg_endian),
    .cfg_bitrev(cfg_bitrev), .cfg_bytemode(cfg_bytemode), .cfg_crc16(cfg_crc16),
    .cfg_init_sel(cfg_init_sel), .start(start), .seed_we(seed_we),
    .seed_data(seed_data), .din_valid(din_valid), .din_data(din_data),
    .crc_out(crc_out)
  );

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
        summary_and_end();
      end
    end
  end

  function automatic logic [31:0] ref_reorder(logic [31:0] w, logic [1:0] code, logic rev);
    logic [7:0] q[$];
    logic [7:0] b3, b2, b1, b0;
    logic [31:0] r;
    {b3, b2, b1, b0} = w;
    case (code)
      2'd0: q = '{b3, b2, b1, b0};
      2'd1: q = '{b2, b3, b0, b1};
      2'd2: q = '{b1, b0, b3, b2};
      default: q = '{b0, b1, b2, b3};
    endcase
    r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = q[i];
      if (rev) for (int j = 0; j < 8; j++) v[j] = q[i][7-j];
      r = {r[23:0], v};
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_fold(logic [31:0] c, logic [31:0] bits, int n, logic n16);
    for (int i = n - 1; i >= 0; i--) begin
      if (n16) begin
        logic fb;
        fb = c[15] ^ bits[i];
        c[15:0] = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        c[31:16] = '0;
      end else begin
        logic fb;
        fb = c[31] ^ bits[i];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_data(logic [31:0] c, logic [31:0] w);
    if (m_byte) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = m_rev ? w[7-j] : w[j];
      return ref_fold(c, {24'h0, v}, 8, m_n16);
    end
    return ref_fold(c, ref_reorder(w, m_endian, m_rev), 32, m_n16);
  endfunction

  function automatic logic [31:0] model_out();
    return m_n16 ? {16'h0, m_crc[15:0]} : m_crc;
  endfunction

  task automatic idle_inputs();
    cfg_we = 0; start = 0; seed_we = 0; din_valid = 0;
    din_data = '0; seed_data = '0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one clock: model advances with current inputs, output compared at next negedge
  task automatic tick(string req);
    logic [31:0] nxt;
    nxt = m_crc;
    if (seed_we) begin
      m_seed = seed_data; nxt = seed_data;
    end else if (start) begin
      nxt = (m_init == 2'd0) ? 32'h0 : (m_init == 2'd1) ? 32'hFFFF_FFFF : m_seed;
    end else if (din_valid) begin
      nxt = ref_data(m_crc, din_data);
    end
    @(posedge clk);
    m_crc = nxt;
    if (cfg_we) begin
      m_endian = cfg_endian; m_rev = cfg_bitrev; m_byte = cfg_bytemode;
      m_n16 = cfg_crc16; m_init = cfg_init_sel;
    end
    @(negedge clk);
    check(req, crc_out, model_out());
    idle_inputs();
  endtask

  task automatic write_cfg(logic [1:0] e, logic r, logic b, logic n, logic [1:0] s);
    cfg_we = 1; cfg_endian = e; cfg_bitrev = r; cfg_bytemode = b; cfg_crc16 = n; cfg_init_sel = s;
    tick("R10");
  endtask

  task automatic push(logic [31:0] w, string req);
    din_valid = 1; din_data = w; tick(req);
  endtask

  task automatic go(string req);
    start = 1; tick(req);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    cfg_endian = 0; cfg_bitrev = 0; cfg_bytemode = 0; cfg_crc16 = 0; cfg_init_sel = 0;
    m_crc = 0; m_seed = 0; m_endian = 0; m_init = 0; m_rev = 0; m_byte = 0; m_n16 = 0;
    repeat (3) @(negedge clk);
    check("R1", crc_out, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", crc_out, 32'h0);
    // reset config is word mode, CRC-32, no reorder: one word folds as plain CRC-32
    push(32'h1234_5678, "R1");

    // known vector: bytes "123456789", all-ones start, no final XOR
    write_cfg(2'd0, 0, 1, 0, 2'd1);
    go("R7");
    for (int i = 0; i < 9; i++) push(32'hABCD_EF00 | (32'h31 + i), "R4");
    check("R5", crc_out, 32'h0376_E6E7);
    write_cfg(2'd0, 0, 1, 1, 2'd1);
    go("R7");
    for (int i = 0; i < 9; i++) push(32'h5500_0000 | (32'h31 + i), "R4");
    check("R6", crc_out, 32'h0000_29B1);

    // every type, size, reverse and swap combination
    for (int n = 0; n < 2; n++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 2; r++)
          for (int e = 0; e < 4; e++) begin
            write_cfg(2'(e), 1'(r), 1'(b), 1'(n), 2'd1);
            go("R7");
            for (int k = 0; k < 5; k++)
              push(32'h0F1E_2D3C ^ (32'(k + e * 7 + r * 3) * 32'h9E37_79B9),
                   r ? "R3" : (b ? "R4" : (n ? "R6" : "R2")));
          end

    // swap codes alone against a single distinctive word
    for (int e = 0; e < 4; e++) begin
      write_cfg(2'(e), 0, 0, 0, 2'd0);
      go("R7");
      push(32'h0102_0304, "R2");
    end

    // byte mode ignores upper bits and swap code: two inputs with same low byte match
    begin
      logic [31:0] a;
      write_cfg(2'd3, 1, 1, 0, 2'd1);
      go("R7");
      push(32'hDEAD_BE5A, "R4");
      a = crc_out;
      write_cfg(2'd1, 1, 1, 0, 2'd1);
      go("R7");
      push(32'h0000_005A, "R4");
      check("R4", crc_out, a);
    end

    // seed paths
    write_cfg(2'd0, 0, 0, 0, 2'd2);
    seed_we = 1; seed_data = 32'hC001_D00D; tick("R8");
    push(32'h7777_0000, "R8");
    go("R7");
    check("R7", crc_out, 32'hC001_D00D);
    write_cfg(2'd0, 0, 0, 0, 2'd3);
    push(32'h1111_2222, "R7");
    go("R7");
    write_cfg(2'd0, 0, 0, 0, 2'd0);
    push(32'h3333_4444, "R7");
    go("R7");
    check("R7", crc_out, 32'h0);

    // collisions: seed write or start with data; seed write with start
    for (int n = 0; n < 2; n++) begin
      write_cfg(2'd2, 0, 0, 1'(n), 2'd1);
      go("R9");
      push(32'hAAAA_5555, "R9");
      seed_we = 1; seed_data = 32'h8765_4321; din_valid = 1; din_data = 32'hFFFF_0000; tick("R9");
      push(32'h0BAD_F00D, "R9");
      start = 1; din_valid = 1; din_data = 32'h1357_9BDF; tick("R9");
      check("R9", crc_out, n ? 32'h0000_FFFF : 32'hFFFF_FFFF);
      seed_we = 1; seed_data = 32'h2468_ACE0; start = 1; tick("R8");
      check("R8", crc_out, n ? 32'h0000_ACE0 : 32'h2468_ACE0);
    end

    // config write with data and with start in the same cycle: old settings apply
    write_cfg(2'd0, 0, 0, 0, 2'd1);
    go("R10");
    cfg_we = 1; cfg_endian = 2'd3; cfg_bitrev = 1; cfg_bytemode = 1; cfg_crc16 = 0; cfg_init_sel = 2'd0;
    din_valid = 1; din_data = 32'hCAFE_F00D; tick("R10");
    push(32'hCAFE_F00D, "R10");
    cfg_we = 1; cfg_endian = 0; cfg_bitrev = 0; cfg_bytemode = 0; cfg_crc16 = 1; cfg_init_sel = 2'd1;
    start = 1; tick("R10");
    check("R10", crc_out, 32'h0);

    // idle cycles hold the value
    push(32'h5A5A_A5A5, "R11");
    repeat (4) tick("R11");

    // reset mid-stream clears the value and the configuration
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1", crc_out, 32'h0);
    @(negedge clk);
    rst_n = 1;
    m_crc = 0; m_seed = 0; m_endian = 0; m_init = 0; m_rev = 0; m_byte = 0; m_n16 = 0;
    push(32'h8000_0001, "R1");
    go("R1");

    summary_and_end();
  end
endmodule